// File: doc/BRIEF.md
# Blanking-Interval Frame Copy Engine

This block sits between a processor and a display pipeline that use two separate byte-wide memories. The processor builds the next image in a source memory that it owns, and the display reads a destination memory. Data moves from source to destination only while the raster is in vertical blanking, so no visible line is ever drawn from a half-updated image.

Software arms a transfer with a one-cycle request pulse. The engine keeps that request pending and looks at it once per frame, on the first clock of vertical blanking. If a request is pending, the engine clears it, takes the source memory port away from the processor, and walks a single shared address counter from zero. It moves one byte per clock and reads each byte one cycle before it writes it. When the last byte is written, the engine releases the port and, if enabled, raises a sticky interrupt that software clears by pulsing a clear input.

The processor port is a plain synchronous memory port with no back-pressure. Writes that arrive while the engine owns the memory are dropped, and each one sets a sticky overflow flag. The transfer length is a fixed parameter. It is reduced at elaboration so that every transfer finishes inside the blanking window and inside the memory.

Top module: `vblank_frame_copier`

## Requirements
- R1: After reset, busy, irq, overflow and go_pending are all 0.
- R2: A go_set pulse only sets go_pending and does not start a transfer. A transfer starts only on the first clock of vertical blanking, and busy rises on the clock edge after in_vblank rises.
- R3: go_pending falls on the same edge on which busy rises, so each request causes exactly one transfer.
- R4: A transfer copies source byte i to destination byte i for every i from 0 to N-1. N is the effective byte count, and no destination address at or above N is written.
- R5: busy stays high for exactly N+1 clocks: N reads, with the last write one cycle behind the last read.
- R6: A CPU write while busy is high leaves the source memory unchanged and sets overflow, which then stays at 1 until reset.
- R7: When irq_en is 1, irq rises on the edge on which busy falls and holds until an irq_clr pulse. When irq_en is 0, a finished transfer leaves irq at 0.
- R8: N = min(COPY_BYTES, blank clocks - 2, DEPTH), where blank clocks = (V_TOTAL - V_VIS) * H_TOTAL. busy is never high outside vertical blanking.
- R9: At a blanking start with no request pending, busy stays low for the whole frame.
- R10: When busy is low, cpu_rdata shows the source byte at cpu_addr one clock after the address is presented.
- R11: in_vblank is high for (V_TOTAL - V_VIS) * H_TOTAL consecutive clocks out of every H_TOTAL * V_TOTAL clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | CPU write strobe to the source memory (dropped while busy) |
| cpu_addr | input | ADDR_W | CPU address into the source memory |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Source byte read, one-clock latency |
| go_set | input | 1 | Pulse that arms a transfer for the next blanking start |
| irq_en | input | 1 | Enables setting irq when a transfer completes |
| irq_clr | input | 1 | Pulse that clears irq |
| busy | output | 1 | Engine owns the source memory |
| go_pending | output | 1 | A transfer request is waiting |
| irq | output | 1 | Sticky completion interrupt |
| overflow | output | 1 | Sticky flag: a CPU write was dropped |
| in_vblank | output | 1 | Raster is in vertical blanking |
| vid_addr | input | ADDR_W | Display read address into the destination memory |
| vid_rdata | output | 8 | Destination byte read, one-clock latency |

## Verification
Every result is sampled on the falling edge that follows the rising edge at which it becomes due. Memory reads are checked one clock after the address is driven. busy is checked low on the first falling edge with in_vblank high and high on the next one, and go_pending is checked low on that same edge. The bench counts busy cycles until busy falls and expects N+1 of them, with irq checked on the first falling edge at which busy is low. A second instance built with an oversized byte count is watched over the same frame to confirm the reduced length and that its busy stays inside blanking.

// File: rtl/fce_pkg.sv
package fce_pkg;
  typedef enum logic {ENG_IDLE, ENG_COPY} eng_state_e;

  function automatic int min3(input int a, input int b, input int c);
    int m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction
endpackage

// File: rtl/fce_raster.sv
module fce_raster #(
  parameter int H_TOTAL = 16,
  parameter int V_TOTAL = 10,
  parameter int V_VIS   = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic vblank,
  output logic vb_start
);
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (hcnt == HW'(H_TOTAL - 1)) begin
      hcnt <= '0;
      vcnt <= (vcnt == VW'(V_TOTAL - 1)) ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assign vblank   = (vcnt >= VW'(V_VIS));
  assign vb_start = (vcnt == VW'(V_VIS)) && (hcnt == '0);
endmodule

// File: rtl/fce_byte_ram.sv
module fce_byte_ram #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fce_copy_engine.sv
module fce_copy_engine
  import fce_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vb_start,
  input  logic              vblank,
  input  logic              go_set,
  input  logic              irq_en,
  input  logic              irq_clr,
  output logic              busy,
  output logic              go_pending,
  output logic              irq,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr
);
  localparam int CNT_W = ADDR_W + 1;

  eng_state_e       state;
  logic [CNT_W-1:0] rd_cnt;
  logic             rd_en;
  logic             start;
  logic             last;

  assign start   = (state == ENG_IDLE) && vb_start && go_pending;
  assign rd_en   = (state == ENG_COPY) && (rd_cnt != CNT_W'(NBYTES));
  assign last    = wr_en && (wr_addr == ADDR_W'(NBYTES - 1));
  assign busy    = (state == ENG_COPY);
  assign rd_addr = rd_cnt[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ENG_IDLE;
      rd_cnt     <= '0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      go_pending <= 1'b0;
      irq        <= 1'b0;
    end else begin
      go_pending <= start ? 1'b0 : (go_pending | go_set);
      case (state)
        ENG_IDLE: if (start) state <= ENG_COPY;
        ENG_COPY: if (last)  state <= ENG_IDLE;
        default:             state <= ENG_IDLE;
      endcase
      if (start)      rd_cnt <= '0;
      else if (rd_en) rd_cnt <= rd_cnt + 1'b1;
      wr_en   <= rd_en;
      wr_addr <= rd_cnt[ADDR_W-1:0];
      if (last && irq_en) irq <= 1'b1;
      else if (irq_clr)   irq <= 1'b0;
    end
  end

  // R2
  start_at_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(vb_start));
  // R3
  go_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !go_pending);
  // R8
  busy_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> vblank);
  // R4
  dst_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, wr_addr} < CNT_W'(NBYTES)));
  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
endmodule

// File: rtl/vblank_frame_copier.sv
module vblank_frame_copier
  import fce_pkg::*;
#(
  parameter int H_TOTAL    = 16,
  parameter int V_TOTAL    = 10,
  parameter int V_VIS      = 6,
  parameter int DEPTH      = 64,
  parameter int COPY_BYTES = 48,
  localparam int ADDR_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic              go_set,
  input  logic              irq_en,
  input  logic              irq_clr,
  output logic              busy,
  output logic              go_pending,
  output logic              irq,
  output logic              overflow,
  output logic              in_vblank,
  input  logic [ADDR_W-1:0] vid_addr,
  output logic [7:0]        vid_rdata
);
  localparam int VB_CLKS = (V_TOTAL - V_VIS) * H_TOTAL;
  localparam int NBYTES  = min3(COPY_BYTES, VB_CLKS - 2, DEPTH);

  logic              vb_start;
  logic [ADDR_W-1:0] eng_rd_addr;
  logic              eng_wr_en;
  logic [ADDR_W-1:0] eng_wr_addr;
  logic [ADDR_W-1:0] src_addr;
  logic              src_we;
  logic [7:0]        src_rdata;

  fce_raster #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .V_VIS(V_VIS)) u_raster (
    .clk(clk), .rst_n(rst_n), .vblank(in_vblank), .vb_start(vb_start)
  );

  fce_copy_engine #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_engine (
    .clk(clk), .rst_n(rst_n), .vb_start(vb_start), .vblank(in_vblank),
    .go_set(go_set), .irq_en(irq_en), .irq_clr(irq_clr),
    .busy(busy), .go_pending(go_pending), .irq(irq),
    .rd_addr(eng_rd_addr), .wr_en(eng_wr_en), .wr_addr(eng_wr_addr)
  );

  assign src_addr  = busy ? eng_rd_addr : cpu_addr;
  assign src_we    = cpu_wr_en && !busy;
  assign cpu_rdata = src_rdata;

  fce_byte_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_src_ram (
    .clk(clk), .we(src_we), .waddr(src_addr), .wdata(cpu_wdata),
    .raddr(src_addr), .rdata(src_rdata)
  );

  fce_byte_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dst_ram (
    .clk(clk), .we(eng_wr_en), .waddr(eng_wr_addr), .wdata(src_rdata),
    .raddr(vid_addr), .rdata(vid_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                     overflow <= 1'b0;
    else if (busy && cpu_wr_en)     overflow <= 1'b1;
  end

  // R6
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cpu_wr_en) |=> overflow);
  // R6
  drop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

// File: tb/test_vblank_frame_copier.sv
`timescale 1ns/1ps
module test_vblank_frame_copier;
  localparam int DEPTH = 64;
  localparam int AW    = 6;
  localparam int N     = 48;
  localparam int NCLMP = 62;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr_en = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic go_set = 1'b0, irq_en = 1'b0, irq_clr = 1'b0;
  logic [AW-1:0] vid_addr = '0;
  logic [7:0] cpu_rdata, vid_rdata, cpu_rdata_c, vid_rdata_c;
  logic busy, go_pending, irq, overflow, in_vblank;
  logic busy_c, go_pending_c, irq_c, overflow_c, in_vblank_c;
  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  vblank_frame_copier i_vblank_frame_copier (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .go_set(go_set), .irq_en(irq_en),
    .irq_clr(irq_clr), .busy(busy), .go_pending(go_pending), .irq(irq),
    .overflow(overflow), .in_vblank(in_vblank), .vid_addr(vid_addr), .vid_rdata(vid_rdata)
  );

  vblank_frame_copier #(.COPY_BYTES(100)) i_clamp (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata_c), .go_set(go_set), .irq_en(irq_en),
    .irq_clr(irq_clr), .busy(busy_c), .go_pending(go_pending_c), .irq(irq_c),
    .overflow(overflow_c), .in_vblank(in_vblank_c), .vid_addr(vid_addr), .vid_rdata(vid_rdata_c)
  );

  function automatic logic [7:0] pat_a(input int i); return 8'(i * 7 + 3) ^ 8'hA5; endfunction
  function automatic logic [7:0] pat_b(input int i); return 8'(i * 13 + 1); endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic fill(input bit use_b);
    for (int i = 0; i < DEPTH; i++) begin
      cpu_wr_en = 1'b1; cpu_addr = AW'(i);
      cpu_wdata = use_b ? pat_b(i) : pat_a(i);
      tick();
    end
    cpu_wr_en = 1'b0;
  endtask

  task automatic pulse_go();
    go_set = 1'b1; tick(); go_set = 1'b0;
  endtask

  task automatic wait_blank_rise();
    while (in_vblank) tick();
    while (!in_vblank) tick();
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0); chk("R1 irq", irq, 0);
    chk("R1 overflow", overflow, 0); chk("R1 go_pending", go_pending, 0);
  endtask

  task automatic t_frame();
    int hi = 0, lo = 0;
    wait_blank_rise();
    while (in_vblank) begin hi++; tick(); end
    while (!in_vblank) begin lo++; tick(); end
    chk("R11 blank length", hi, 64);
    chk("R11 frame length", hi + lo, 160);
  endtask

  task automatic t_cpu_read();
    for (int i = 0; i < DEPTH; i += 9) begin
      cpu_addr = AW'(i); tick();
      chk("R10 cpu read", cpu_rdata, pat_a(i));
    end
  endtask

  task automatic t_no_go();
    int cnt = 0;
    wait_blank_rise();
    for (int k = 0; k < 160; k++) begin
      if (busy) cnt++;
      tick();
    end
    chk("R9 no transfer without request", cnt, 0);
  endtask

  // Armed transfer; optionally drops a CPU write during busy.
  task automatic t_copy(input bit use_b, input bit en, input bit poke);
    int cnt = 0, cnt_c = 0, outside = 0;
    while (in_vblank) tick();
    irq_en = en;
    pulse_go();
    chk("R2 pending after pulse", go_pending, 1);
    chk("R2 no immediate start", busy, 0);
    while (!in_vblank) tick();
    chk("R2 busy low on first blank clock", busy, 0);
    tick();
    chk("R2 busy rises next clock", busy, 1);
    chk("R3 request consumed", go_pending, 0);
    while (busy || busy_c) begin
      if (busy) cnt++;
      if (busy_c) begin cnt_c++; if (!in_vblank) outside++; end
      if (poke && cnt == 3) begin cpu_wr_en = 1'b1; cpu_addr = AW'(5); cpu_wdata = 8'hEE; end
      else cpu_wr_en = 1'b0;
      tick();
      if (!busy && cnt == N + 1 && en) begin
        if (cnt_c == N + 1) chk("R7 irq at busy fall", irq, 1);
      end
    end
    cpu_wr_en = 1'b0;
    chk("R5 busy length", cnt, N + 1);
    chk("R8 clamped busy length", cnt_c, NCLMP + 1);
    chk("R8 clamped busy inside blank", outside, 0);
    chk("R7 irq after transfer", irq, en ? 1 : 0);
    for (int i = 0; i < N; i++) begin
      vid_addr = AW'(i); tick();
      chk("R4 destination byte", vid_rdata, use_b ? pat_b(i) : pat_a(i));
    end
    if (poke) begin
      cpu_addr = AW'(5); tick();
      chk("R6 dropped write", cpu_rdata, pat_b(5));
      chk("R6 overflow set", overflow, 1);
      tick(); tick();
      chk("R6 overflow sticky", overflow, 1);
    end
  endtask

  task automatic t_irq_clear();
    tick(); tick();
    chk("R7 irq holds", irq, 1);
    irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    chk("R7 irq cleared", irq, 0);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    fill(1'b0);
    chk("R6 overflow clear before transfers", overflow, 0);
    t_cpu_read();
    t_frame();
    t_no_go();
    t_copy(1'b0, 1'b1, 1'b0);
    t_irq_clear();
    fill(1'b1);
    t_copy(1'b1, 1'b1, 1'b1);
    t_irq_clear();
    t_copy(1'b1, 1'b0, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule